// File: doc/BRIEF.md
# Motor Coil PWM Channel

This block generates the drive for one motor coil from a shared, free-running timer counter that lives outside it. Each timer step is marked by a one-cycle enable. The last step of every frame also carries an overflow flag. Software-side writes set the period-relative duty magnitude, a sign, an alignment, a pin mode and a delay of zero to three timer steps. These writes land in shadow registers. The shadow contents move into the working set at the frame boundary. When the channel cannot be producing a frame, because every channel is switched off or the period is zero, they move at once.

The block has two pins, minus and plus. Each pin has its own output-enable, so either pin can be let go (tri-stated) by the pad. In half-bridge mode one pin carries the PWM and the other is released. In full-bridge mode the sign picks the carrying pin and the other pin is held inactive. Dual full-bridge mode drives this channel the same way as full-bridge mode. The shadow alignment and pin mode can be read back at any time.

Top module: `motor_pwm_channel`

## Requirements
- R1: During reset and on the first cycle after it, both output-enables are 0, both pins are 0, and the read-back alignment and mode are 0.
- R2: A write (cfg_we high for one cycle) shows on rd_align and rd_omode from the next cycle. While the timer runs with a nonzero period and all_dis_i low, the pins do not change until the next overflow.
- R3: The working set loads the shadow on the clock edge of a timer step that has tc_ovf set. A write made in that same cycle is not taken; it takes effect at the following overflow.
- R4: While all_dis_i is 1 or period_i is 0, the working set follows the shadow on every clock. A write is therefore in force two cycles after its cfg_we cycle.
- R5: Alignment code 01 (left) gives a high level while count < duty.
- R6: Alignment code 10 (right) gives a high level while count >= period - duty.
- R7: Alignment code 11 (center) gives a high level while lead <= count < lead + duty, where lead = (period - duty) / 2 rounded down.
- R8: A duty of 0 gives a level that stays low for the whole frame. A duty at or above the period gives a level that stays high for the whole frame; such a duty is treated as equal to the period.
- R9: Mode 00 enables the minus pin only and puts the PWM on it. Mode 01 enables the plus pin only and puts the PWM on it.
- R10: Modes 10 and 11 enable both pins. With sign 0 the PWM goes on the plus pin and the minus pin is held 0. With sign 1 the PWM goes on the minus pin and the plus pin is held 0.
- R11: With delay d, the pin values after timer step k are the values step k-d would have given. With d = 0 they appear on the clock after the step. Before any step has occurred they are 0.
- R12: Alignment code 00 or a zero period_i clears both output-enables, and a pin whose enable is 0 reads 0. The release follows the working set with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_tick | input | 1 | Timer counter step enable |
| tc_cnt | input | CNT_W | Current timer count |
| tc_ovf | input | 1 | Marks the last step of a frame (with tc_tick) |
| period_i | input | CNT_W | Shared frame period, 0 means stopped |
| all_dis_i | input | 1 | All channels of the group are switched off |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_duty | input | CNT_W | Duty magnitude |
| cfg_sign | input | 1 | Duty sign (pin choice in full-bridge modes) |
| cfg_align | input | 2 | Alignment: 00 off, 01 left, 10 right, 11 center |
| cfg_omode | input | 2 | Pin mode: 00 half minus, 01 half plus, 10 full, 11 dual full |
| cfg_delay | input | 2 | Output delay in timer steps |
| pin_m | output | 1 | Minus pin data |
| pin_m_oe | output | 1 | Minus pin output-enable |
| pin_p | output | 1 | Plus pin data |
| pin_p_oe | output | 1 | Plus pin output-enable |
| rd_align | output | 2 | Shadow alignment read-back |
| rd_omode | output | 2 | Shadow pin mode read-back |

## Verification
A configuration write and the frame-boundary load can fall in the same clock cycle. The shadow register is written on the same edge as the working set loads from it. The bench provokes this by raising cfg_we on the overflow step itself, with a write that switches the channel off. It judges the result by the output-enables, which must stay on through the following frame and drop only after the next overflow, while rd_align already shows the new value. A second overlap comes from a nonzero delay at the boundary. There the pins keep playing out the old frame's last steps while the new working set is already in force, and the bench compares each of those steps against its history of expected levels.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;

  typedef enum logic [1:0] {
    ALIGN_OFF    = 2'b00,
    ALIGN_LEFT   = 2'b01,
    ALIGN_RIGHT  = 2'b10,
    ALIGN_CENTER = 2'b11
  } align_e;

  typedef enum logic [1:0] {
    PM_HALF_MINUS = 2'b00,
    PM_HALF_PLUS  = 2'b01,
    PM_FULL       = 2'b10,
    PM_DUAL       = 2'b11
  } pin_mode_e;

  // Pin pair packing: bit 1 = minus pin, bit 0 = plus pin.
  function automatic logic [1:0] route_level(input logic [1:0] mode,
                                             input logic sign,
                                             input logic lvl);
    logic [1:0] pins;
    case (mode)
      PM_HALF_MINUS: pins = {lvl, 1'b0};
      PM_HALF_PLUS:  pins = {1'b0, lvl};
      default:       pins = sign ? {lvl, 1'b0} : {1'b0, lvl};
    endcase
    return pins;
  endfunction

endpackage

// File: rtl/motor_pwm_cfg_regs.sv
module motor_pwm_cfg_regs
  import motor_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic             cfg_sign,
  input  logic [1:0]       cfg_align,
  input  logic [1:0]       cfg_omode,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             tc_tick,
  input  logic             tc_ovf,
  input  logic             all_dis_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [1:0]       shd_align,
  output logic [1:0]       shd_omode,
  output logic [CNT_W-1:0] act_duty,
  output logic             act_sign,
  output logic [1:0]       act_align,
  output logic [1:0]       act_omode,
  output logic [DLY_W-1:0] act_delay,
  output logic             load_now
);

  logic [CNT_W-1:0] shd_duty;
  logic             shd_sign;
  logic [DLY_W-1:0] shd_delay;
  logic             idle_load;
  logic             frame_end;

  assign idle_load = all_dis_i || (period_i == '0);
  assign frame_end = tc_tick && tc_ovf;
  assign load_now  = idle_load || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_duty  <= '0;
      shd_sign  <= 1'b0;
      shd_align <= ALIGN_OFF;
      shd_omode <= PM_HALF_MINUS;
      shd_delay <= '0;
    end else if (cfg_we) begin
      shd_duty  <= cfg_duty;
      shd_sign  <= cfg_sign;
      shd_align <= cfg_align;
      shd_omode <= cfg_omode;
      shd_delay <= cfg_delay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_duty  <= '0;
      act_sign  <= 1'b0;
      act_align <= ALIGN_OFF;
      act_omode <= PM_HALF_MINUS;
      act_delay <= '0;
    end else if (load_now) begin
      act_duty  <= shd_duty;
      act_sign  <= shd_sign;
      act_align <= shd_align;
      act_omode <= shd_omode;
      act_delay <= shd_delay;
    end
  end

endmodule

// File: rtl/motor_pwm_wave.sv
module motor_pwm_wave
  import motor_pwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic             sign,
  input  logic [1:0]       align,
  input  logic [1:0]       omode,
  output logic             level,
  output logic [1:0]       pins
);

  function automatic logic calc_level(input logic [1:0] al,
                                      input logic [CNT_W-1:0] c,
                                      input logic [CNT_W-1:0] per,
                                      input logic [CNT_W-1:0] du);
    logic [CNT_W-1:0] d;
    logic [CNT_W-1:0] lead;
    logic             on;
    d    = (du > per) ? per : du;
    lead = (per - d) >> 1;
    on   = 1'b0;
    if (per != '0 && du != '0) begin
      case (al)
        ALIGN_LEFT:   on = (c < d);
        ALIGN_RIGHT:  on = (c >= per - d);
        ALIGN_CENTER: on = (c >= lead) && ((c - lead) < d);
        default:      on = 1'b0;
      endcase
    end
    return on;
  endfunction

  assign level = calc_level(align, cnt, period, duty);
  assign pins  = route_level(omode, sign, level);

endmodule

// File: rtl/motor_pwm_delay.sv
module motor_pwm_delay #(
  parameter int DLY_W = 2,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tc_tick,
  input  logic [LANES-1:0] din,
  input  logic [DLY_W-1:0] sel,
  output logic [LANES-1:0] dout
);

  localparam int DEPTH = 1 << DLY_W;

  logic [LANES-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[i] <= '0;
      end else if (tc_tick) begin
        if (i == 0) begin
          stage[i] <= din;
        end else begin
          stage[i] <= stage[i-1];
        end
      end
    end
  end

  assign dout = stage[sel];

endmodule

// File: rtl/motor_pwm_channel.sv
module motor_pwm_channel
  import motor_pwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tc_tick,
  input  logic [CNT_W-1:0] tc_cnt,
  input  logic             tc_ovf,
  input  logic [CNT_W-1:0] period_i,
  input  logic             all_dis_i,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_duty,
  input  logic             cfg_sign,
  input  logic [1:0]       cfg_align,
  input  logic [1:0]       cfg_omode,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             pin_m,
  output logic             pin_m_oe,
  output logic             pin_p,
  output logic             pin_p_oe,
  output logic [1:0]       rd_align,
  output logic [1:0]       rd_omode
);

  localparam int LANES = 2;

  logic [CNT_W-1:0] work_duty_w;
  logic             work_sign_w;
  logic [1:0]       work_align_w;
  logic [1:0]       work_omode_w;
  logic [DLY_W-1:0] work_delay_w;
  logic             load_now_w;
  logic             level_w;
  logic [1:0]       mapped_w;
  logic [1:0]       delayed_w;
  logic             drive_en_w;

  motor_pwm_cfg_regs #(.CNT_W(CNT_W), .DLY_W(DLY_W)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_duty  (cfg_duty),
    .cfg_sign  (cfg_sign),
    .cfg_align (cfg_align),
    .cfg_omode (cfg_omode),
    .cfg_delay (cfg_delay),
    .tc_tick   (tc_tick),
    .tc_ovf    (tc_ovf),
    .all_dis_i (all_dis_i),
    .period_i  (period_i),
    .shd_align (rd_align),
    .shd_omode (rd_omode),
    .act_duty  (work_duty_w),
    .act_sign  (work_sign_w),
    .act_align (work_align_w),
    .act_omode (work_omode_w),
    .act_delay (work_delay_w),
    .load_now  (load_now_w)
  );

  motor_pwm_wave #(.CNT_W(CNT_W)) wave_i (
    .cnt    (tc_cnt),
    .period (period_i),
    .duty   (work_duty_w),
    .sign   (work_sign_w),
    .align  (work_align_w),
    .omode  (work_omode_w),
    .level  (level_w),
    .pins   (mapped_w)
  );

  motor_pwm_delay #(.DLY_W(DLY_W), .LANES(LANES)) dly_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tc_tick (tc_tick),
    .din     (mapped_w),
    .sel     (work_delay_w),
    .dout    (delayed_w)
  );

  // Release is taken from the working set directly, never through the delay line.
  assign drive_en_w = (work_align_w != ALIGN_OFF) && (period_i != '0);
  assign pin_m_oe   = drive_en_w && (work_omode_w != PM_HALF_PLUS);
  assign pin_p_oe   = drive_en_w && (work_omode_w != PM_HALF_MINUS);
  assign pin_m      = pin_m_oe && delayed_w[1];
  assign pin_p      = pin_p_oe && delayed_w[0];

endmodule

// File: rtl/motor_pwm_channel_chk.sv
module motor_pwm_channel_chk #(
  parameter int CNT_W = 8,
  parameter int DLY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tc_tick,
  input logic             all_dis_i,
  input logic [CNT_W-1:0] period_i,
  input logic             cfg_we,
  input logic             pin_m,
  input logic             pin_m_oe,
  input logic             pin_p,
  input logic             pin_p_oe,
  input logic [1:0]       rd_align,
  input logic [1:0]       work_align_w,
  input logic [1:0]       work_omode_w,
  input logic [DLY_W-1:0] work_delay_w,
  input logic             load_now_w,
  input logic [1:0]       mapped_w
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pin_m_oe && !pin_p_oe && !pin_m && !pin_p));

  a_r12_minus_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_m_oe |-> !pin_m);

  a_r12_plus_released_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_p_oe |-> !pin_p);

  a_r9_half_minus_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_m_oe || pin_p_oe) && work_omode_w == 2'b00) |-> (pin_m_oe && !pin_p_oe));

  a_r3_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !load_now_w |=> ($stable(work_align_w) && $stable(work_omode_w) && $stable(work_delay_w)));

  a_r4_idle_follows_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    ((all_dis_i || period_i == '0) && !cfg_we) |=> (work_align_w == rd_align));

  a_r11_zero_delay_next_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_tick && work_delay_w == '0 && !load_now_w) |=> (pin_m == (pin_m_oe && $past(mapped_w[1]))));

endmodule

bind motor_pwm_channel motor_pwm_channel_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .tc_tick      (tc_tick),
  .all_dis_i    (all_dis_i),
  .period_i     (period_i),
  .cfg_we       (cfg_we),
  .pin_m        (pin_m),
  .pin_m_oe     (pin_m_oe),
  .pin_p        (pin_p),
  .pin_p_oe     (pin_p_oe),
  .rd_align     (rd_align),
  .work_align_w (work_align_w),
  .work_omode_w (work_omode_w),
  .work_delay_w (work_delay_w),
  .load_now_w   (load_now_w),
  .mapped_w     (mapped_w)
);

// File: tb/motor_pwm_channel_tb_top.sv
module motor_pwm_channel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int DLY_W      = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tc_tick = 1'b0;
  logic [CNT_W-1:0] tc_cnt = '0;
  logic             tc_ovf = 1'b0;
  logic [CNT_W-1:0] period_i = 8'd10;
  logic             all_dis_i = 1'b0;
  logic             cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_duty = '0;
  logic             cfg_sign = 1'b0;
  logic [1:0]       cfg_align = '0;
  logic [1:0]       cfg_omode = '0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic             pin_m, pin_m_oe, pin_p, pin_p_oe;
  logic [1:0]       rd_align, rd_omode;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    mon_en   = 1'b0;
  bit    done     = 1'b0;

  // Requirement-level model state (shadow and working copies)
  int s_align, s_omode, s_sign, s_duty, s_delay;
  int w_align, w_omode, w_sign, w_duty, w_delay;
  bit [1:0] hist_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_pwm_channel #(.CNT_W(CNT_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tc_tick(tc_tick), .tc_cnt(tc_cnt), .tc_ovf(tc_ovf),
    .period_i(period_i), .all_dis_i(all_dis_i), .cfg_we(cfg_we), .cfg_duty(cfg_duty),
    .cfg_sign(cfg_sign), .cfg_align(cfg_align), .cfg_omode(cfg_omode), .cfg_delay(cfg_delay),
    .pin_m(pin_m), .pin_m_oe(pin_m_oe), .pin_p(pin_p), .pin_p_oe(pin_p_oe),
    .rd_align(rd_align), .rd_omode(rd_omode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // R5 R6 R7 R8: level of one timer step
  function automatic bit lvl_of(int al, int c, int p, int du);
    int d;
    int lead;
    if (p == 0 || du == 0) return 1'b0;
    d = (du > p) ? p : du;
    case (al)
      1: return c < d;
      2: return (p - c) <= d;
      3: begin
        lead = (p - d) / 2;
        return (c >= lead) && (c - lead < d);
      end
      default: return 1'b0;
    endcase
  endfunction

  // R9 R10: pin pair {minus, plus}
  function automatic bit [1:0] pins_of(int om, int sg, bit l);
    if (om == 0) return {l, 1'b0};
    if (om == 1) return {1'b0, l};
    return (sg != 0) ? {l, 1'b0} : {1'b0, l};
  endfunction

  // Driver-side model: expected items enter the scoreboard queue on every step.
  always @(posedge clk) begin
    if (!rst_n) begin
      hist_q.delete();
      s_align = 0; s_omode = 0; s_sign = 0; s_duty = 0; s_delay = 0;
      w_align = 0; w_omode = 0; w_sign = 0; w_duty = 0; w_delay = 0;
    end else begin
      if (tc_tick) begin
        hist_q.push_back(pins_of(w_omode, w_sign,
                                 lvl_of(w_align, int'(tc_cnt), int'(period_i), w_duty)));
        if (hist_q.size() > 8) void'(hist_q.pop_front());
      end
      if (all_dis_i || period_i == 0 || (tc_tick && tc_ovf)) begin
        w_align = s_align; w_omode = s_omode; w_sign = s_sign;
        w_duty = s_duty; w_delay = s_delay;
      end
      if (cfg_we) begin
        s_align = int'(cfg_align); s_omode = int'(cfg_omode); s_sign = int'(cfg_sign);
        s_duty = int'(cfg_duty); s_delay = int'(cfg_delay);
      end
    end
  end

  // Monitor: pops the item due at the current delay and compares, away from the edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && mon_en) begin
      bit       eo_m, eo_p;
      bit [1:0] v;
      eo_m = (w_align != 0) && (period_i != 0) && (w_omode != 1);
      eo_p = (w_align != 0) && (period_i != 0) && (w_omode != 0);
      v = (hist_q.size() > w_delay) ? hist_q[hist_q.size() - 1 - w_delay] : 2'b00;
      check({pin_m_oe, pin_p_oe} == {eo_m, eo_p}, cur_req, "enables",
            int'({pin_m_oe, pin_p_oe}), int'({eo_m, eo_p}));
      check({pin_m, pin_p} == ({eo_m, eo_p} & v), cur_req, "pins",
            int'({pin_m, pin_p}), int'({eo_m, eo_p} & v));
    end
  end

  task automatic stage_cfg(int al, int om, int sg, int du, int dl);
    cfg_align = al[1:0]; cfg_omode = om[1:0]; cfg_sign = sg[0];
    cfg_duty = du[CNT_W-1:0]; cfg_delay = dl[DLY_W-1:0];
  endtask

  task automatic cfg_write(int al, int om, int sg, int du, int dl);
    @(negedge clk);
    stage_cfg(al, om, sg, du, dl);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs whole frames; optionally writes the staged config on the final overflow step.
  task automatic run_frames(int n, bit wr_on_last);
    for (int f = 0; f < n; f++) begin
      for (int c = 0; c < int'(period_i); c++) begin
        @(negedge clk);
        tc_tick = 1'b1;
        tc_cnt  = c[CNT_W-1:0];
        tc_ovf  = (c == int'(period_i) - 1);
        cfg_we  = wr_on_last && tc_ovf && (f == n - 1);
        @(negedge clk);
        tc_tick = 1'b0; tc_ovf = 1'b0; cfg_we = 1'b0;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(!pin_m_oe && !pin_p_oe && !pin_m && !pin_p, "R1", "pins in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({pin_m_oe, pin_p_oe, pin_m, pin_p} == 4'b0, "R1", "pins after reset",
          int'({pin_m_oe, pin_p_oe, pin_m, pin_p}), 0);
    check(rd_align == 0 && rd_omode == 0, "R1", "read-back after reset",
          int'({rd_align, rd_omode}), 0);
    mon_en = 1'b1;

    // R2: shadow visible, output untouched before overflow
    cur_req = "R2";
    cfg_write(1, 2, 0, 3, 0);
    check(rd_align == 2'b01, "R2", "rd_align", int'(rd_align), 1);
    check(rd_omode == 2'b10, "R2", "rd_omode", int'(rd_omode), 2);
    check(!pin_m_oe && !pin_p_oe, "R2", "no drive before overflow",
          int'({pin_m_oe, pin_p_oe}), 0);
    run_frames(1, 0);
    cur_req = "R3";
    check(pin_m_oe && pin_p_oe, "R3", "drive after overflow", int'({pin_m_oe, pin_p_oe}), 3);
    cur_req = "R5 R10";  run_frames(2, 0);
    cfg_write(2, 2, 0, 4, 0);  cur_req = "R6";  run_frames(3, 0);
    cfg_write(3, 2, 0, 4, 0);  cur_req = "R7";  run_frames(2, 0);
    cfg_write(3, 2, 0, 5, 0);  cur_req = "R7";  run_frames(2, 0);
    cfg_write(1, 2, 0, 0, 0);  cur_req = "R8";  run_frames(2, 0);
    cfg_write(1, 2, 0, 12, 0); cur_req = "R8";  run_frames(2, 0);
    cfg_write(2, 0, 0, 6, 0);  cur_req = "R9";  run_frames(2, 0);
    check(pin_m_oe && !pin_p_oe, "R9", "half minus enables", int'({pin_m_oe, pin_p_oe}), 2);
    cfg_write(2, 1, 0, 6, 0);  cur_req = "R9";  run_frames(2, 0);
    check(!pin_m_oe && pin_p_oe, "R9", "half plus enables", int'({pin_m_oe, pin_p_oe}), 1);
    cfg_write(1, 2, 1, 7, 0);  cur_req = "R10"; run_frames(2, 0);
    cfg_write(3, 3, 1, 3, 0);  cur_req = "R10"; run_frames(2, 0);
    cfg_write(1, 2, 0, 2, 1);  cur_req = "R11"; run_frames(2, 0);
    cfg_write(2, 0, 0, 3, 2);  cur_req = "R11"; run_frames(2, 0);
    cfg_write(3, 2, 1, 4, 3);  cur_req = "R11"; run_frames(3, 0);

    // R3 collision: switch-off write lands on the overflow step itself
    cur_req = "R3";
    stage_cfg(0, 2, 0, 4, 0);
    run_frames(1, 1);
    check(rd_align == 2'b00, "R3", "shadow took collided write", int'(rd_align), 0);
    check(pin_m_oe && pin_p_oe, "R3", "old set kept one more frame",
          int'({pin_m_oe, pin_p_oe}), 3);
    run_frames(1, 0);
    cur_req = "R12";
    check(!pin_m_oe && !pin_p_oe, "R12", "released after next overflow",
          int'({pin_m_oe, pin_p_oe}), 0);
    run_frames(1, 0);

    // R4: immediate load while every channel is off
    cur_req = "R4";
    all_dis_i = 1'b1;
    cfg_write(1, 2, 0, 5, 0);
    @(negedge clk);
    check(pin_m_oe && pin_p_oe, "R4", "loaded without overflow", int'({pin_m_oe, pin_p_oe}), 3);
    all_dis_i = 1'b0;
    run_frames(1, 0);

    // R12: zero period releases at once
    cur_req = "R12";
    @(negedge clk);
    period_i = '0;
    @(negedge clk);
    check(!pin_m_oe && !pin_p_oe, "R12", "zero period release", int'({pin_m_oe, pin_p_oe}), 0);
    cur_req = "R4";
    cfg_write(2, 1, 0, 3, 0);
    @(negedge clk);
    period_i = 8'd10;
    @(negedge clk);
    check(!pin_m_oe && pin_p_oe, "R4", "zero period immediate load",
          int'({pin_m_oe, pin_p_oe}), 1);
    cur_req = "R6";
    run_frames(2, 0);

    mon_en = 1'b0;
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule